// File: doc/BRIEF.md
# 64b/66b Transmit Gearbox Sequencer

This block takes 66-bit coded blocks (a 2-bit sync header plus a 64-bit payload) from an upstream encoder. It repacks them into an unbroken stream of 64-bit words for a transceiver's parallel data port. Each block is 66 bits and each output word is 64 bits, so two bits are left over on every accepted block. A residue register carries these leftover bits into the next word.

After 32 blocks the residue holds a full 64-bit word. The block then spends one cycle emitting that residue and accepts no input on that cycle. A per-lane sequencer controls this. It has two states:
- `ST_FILL` covers sequence slots 0 to 31. In this state the block is ready and each cycle consumes a block.
- `ST_DRAIN` is sequence slot 32. In this state the block is not ready and flushes the residue.

The sequencer makes two transitions:
- `ST_FILL` goes to `ST_DRAIN` after slot 31.
- `ST_DRAIN` always goes back to `ST_FILL` at slot 0.

Every lane carries its own instance, so its pause phase is its own. A source must follow `in_ready` and must not assume that lanes pause together.

The transceiver cannot be stalled. When no block is offered during a filling slot, the block inserts a filler control block so that the bit stream stays continuous.

Top module: `gb66_tx_lane`

## Requirements
- R1: `in_ready` is low on exactly one cycle in every 33. The first low cycle is the 33rd cycle after reset is released, and it is high again on the following cycle.
- R2: An accepted block is the 66-bit value {payload, header}, with the header in the two least significant bits. Its bits enter the output stream least significant bit first, directly after the bits of the previous block.
- R3: On the pause cycle the output word consists entirely of the residue bits held so far, and the residue becomes empty. The next word therefore starts with a block header in bits 1:0.
- R4: A block offered with `in_valid` high while `in_ready` is low is not consumed. Nothing from it appears in the output stream.
- R5: In a filling cycle where `in_valid` is low, a filler block takes the slot. The filler has header 2'b10 and an all-zero payload.
- R6: While the synchronous reset `rst` is high, `out_valid` and `out_word` are 0 and `in_ready` is 1. The first word after reset starts with the header of the first block taken.
- R7: After reset, `out_valid` is high on every cycle. One word is produced per cycle, registered one clock after the slot that formed it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers a block this cycle |
| in_ready | output | 1 | Block is taken when `in_valid` is also high (low on the pause slot) |
| in_hdr | input | 2 | Sync header (2'b01 data, 2'b10 control) |
| in_data | input | 64 | Block payload |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 64 | Packed word to the transceiver |

## Verification
The assertions check the following on every cycle:
- the pause cycle is followed by a ready cycle, and slot 31 leads to a pause;
- the pause word equals the previous residue, and the residue empties after it;
- a block taken in slot 0 places its header at bits 1:0;
- an empty slot 0 yields the bare filler header.

Bit-exact packing across arbitrary mixes of offered, absent and pause-time blocks can only be shown by the bench's scenarios. Those scenarios compare every word against a bit-queue model. The same holds for the period phase after a reset in the middle of a run.

// File: rtl/gb66_pkg.sv
package gb66_pkg;
    parameter int WORD_W = 64;
    parameter int HDR_W  = 2;
    parameter logic [HDR_W-1:0] HDR_DATA = 2'b01;
    parameter logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } seq_state_e;
endpackage

// File: rtl/gb66_seq.sv
module gb66_seq #(
    parameter int PERIOD = 33,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             ready,
    output logic             drain,
    output logic [CNT_W-1:0] slot
);
    import gb66_pkg::*;

    localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(PERIOD - 2);

    seq_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_FILL: begin
                cnt_n = cnt + 1'b1;
                if (cnt == LAST_FILL) state_n = ST_DRAIN;
            end
            ST_DRAIN: begin
                cnt_n   = '0;
                state_n = ST_FILL;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready = 1'b1;
        drain = 1'b0;
        unique case (state)
            ST_FILL:  begin ready = 1'b1; drain = 1'b0; end
            ST_DRAIN: begin ready = 1'b0; drain = 1'b1; end
        endcase
        slot = cnt;
    end

    p_pause_single_r1: assert property (@(posedge clk) disable iff (rst)
        drain |=> ready);

    p_pause_after_last_r1: assert property (@(posedge clk) disable iff (rst)
        (ready && cnt == LAST_FILL) |=> !ready);
endmodule

// File: rtl/gb66_pack.sv
module gb66_pack #(
    parameter int WORD_W = 64,
    parameter int HDR_W  = 2,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              drain,
    input  logic [SLOT_W-1:0] slot,
    input  logic [HDR_W-1:0]  hdr,
    input  logic [WORD_W-1:0] data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    import gb66_pkg::*;

    localparam int BLK_W = WORD_W + HDR_W;
    localparam int CAT_W = 2 * WORD_W;
    localparam int SH_W  = $clog2(CAT_W) + 1;

    logic [WORD_W-1:0] res, res_n, word_n;
    logic [BLK_W-1:0]  blk;
    logic [CAT_W-1:0]  blk_ext, cat;
    logic [SH_W-1:0]   sh;

    always_comb begin
        blk     = take ? {data, hdr} : {{WORD_W{1'b0}}, HDR_CTRL};
        blk_ext = {{(CAT_W - BLK_W){1'b0}}, blk};
        sh      = SH_W'(slot) * SH_W'(HDR_W);
        cat     = {{WORD_W{1'b0}}, res} | (blk_ext << sh);
        if (drain) begin
            word_n = res;
            res_n  = '0;
        end else begin
            word_n = cat[WORD_W-1:0];
            res_n  = cat[CAT_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res       <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            res       <= res_n;
            out_word  <= word_n;
            out_valid <= 1'b1;
        end
    end

    p_residue_empty_r3: assert property (@(posedge clk) disable iff (rst)
        drain |=> (res == '0));

    p_drain_word_r3: assert property (@(posedge clk) disable iff (rst)
        drain |=> (out_word == $past(res)));

    p_hdr_first_r2: assert property (@(posedge clk) disable iff (rst)
        (take && slot == '0) |=> (out_word[HDR_W-1:0] == $past(hdr)));

    p_filler_r5: assert property (@(posedge clk) disable iff (rst)
        (!drain && !take && slot == '0) |=> (out_word == WORD_W'(HDR_CTRL)));
endmodule

// File: rtl/gb66_tx_lane.sv
module gb66_tx_lane #(
    parameter int WORD_W = 64,
    parameter int HDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    localparam int PERIOD = WORD_W / HDR_W + 1;
    localparam int SLOT_W = $clog2(PERIOD);

    logic              drain;
    logic              take;
    logic [SLOT_W-1:0] slot;

    gb66_seq #(.PERIOD(PERIOD), .CNT_W(SLOT_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .ready (in_ready),
        .drain (drain),
        .slot  (slot)
    );

    assign take = in_valid && in_ready;

    gb66_pack #(.WORD_W(WORD_W), .HDR_W(HDR_W), .SLOT_W(SLOT_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .drain     (drain),
        .slot      (slot),
        .hdr       (in_hdr),
        .data      (in_data),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    p_valid_run_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);
endmodule

// File: tb/tb_gb66_tx_lane.sv
`timescale 1ns/1ps
module tb_gb66_tx_lane;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_hdr = 2'b00;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_word;

    always #4 clk = ~clk;

    gb66_tx_lane dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .in_data(in_data), .out_valid(out_valid), .out_word(out_word)
    );

    int   checks = 0;
    int   fails  = 0;
    int   mcnt   = 0;
    logic bq[$];
    bit   have = 1'b0;
    logic [1:0]  p_hdr;
    logic [63:0] p_data;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pop_word();
        logic [63:0] w;
        for (int i = 0; i < 64; i++) w[i] = bq.pop_front();
        return w;
    endfunction

    task automatic push_blk(input logic [65:0] b);
        for (int i = 0; i < 66; i++) bq.push_back(b[i]);
    endtask

    task automatic model_reset();
        mcnt = 0;
        bq.delete();
    endtask

    // called at a negedge; returns at the next negedge
    task automatic step(input logic v, input logic [1:0] h, input logic [63:0] d, output bit took);
        logic        exp_rdy;
        logic [63:0] exp_w;
        string       tag;
        exp_rdy = (mcnt != 32);
        chk(in_ready == exp_rdy, "R1", 64'(in_ready), 64'(exp_rdy));
        in_valid = v; in_hdr = h; in_data = d;
        @(posedge clk);
        took = v && exp_rdy;
        if (mcnt == 32) tag = v ? "R4" : "R3";
        else if (!took) tag = "R5";
        else if (mcnt == 0 && bq.size() == 0) tag = "R6";
        else tag = "R2";
        if (mcnt != 32) push_blk(took ? {d, h} : {64'b0, 2'b10});
        exp_w = pop_word();
        mcnt = (mcnt == 32) ? 0 : mcnt + 1;
        @(negedge clk);
        chk(out_word == exp_w, tag, out_word, exp_w);
        chk(out_valid == 1'b1, "R7", 64'(out_valid), 64'd1);
    endtask

    task automatic run_random(input int n, input int idle_pct);
        bit took;
        for (int i = 0; i < n; i++) begin
            if (!have && ($urandom % 100) >= idle_pct) begin
                have   = 1'b1;
                p_hdr  = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
                p_data = {$urandom, $urandom};
            end
            step(have, p_hdr, p_data, took);
            if (took) have = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b1; in_hdr = 2'b01; in_data = 64'hFFFF_0000_FFFF_0000;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R6", 64'(out_valid), 64'd0);
        chk(out_word == '0, "R6", out_word, 64'd0);
        chk(in_ready == 1'b1, "R6", 64'(in_ready), 64'd1);
        rst = 1'b0;
        in_valid = 1'b0;
        have = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit took;
        void'($urandom(32'd7));
        @(negedge clk);
        do_reset();
        // R6: first block right after reset
        step(1'b1, 2'b01, 64'h0123_4567_89AB_CDEF, took);
        // R1 R2 R4: continuous valid over two periods, pause slots offered
        for (int i = 0; i < 70; i++) begin
            if (!have) begin
                have = 1'b1; p_hdr = 2'b01; p_data = {32'hA5A5_0000 + i, 32'h5A5A_0000 + i};
            end
            step(1'b1, p_hdr, p_data, took);
            if (took) have = 1'b0;
        end
        // R5: idle source
        for (int i = 0; i < 40; i++) step(1'b0, 2'b01, 64'hDEAD_BEEF_DEAD_BEEF, took);
        run_random(1500, 30);
        run_random(300, 0);
        // R6: mid-run reset realigns the period
        do_reset();
        step(1'b1, 2'b10, 64'hCAFE_F00D_1234_5678, took);
        run_random(200, 40);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule